// File: doc/BRIEF.md
# Chainable SPI Command Receiver with Length Check

This block is the serial front end of a driver device that sits on a shared SPI chain. While the chip select is low it takes a command word in on its serial input and, in the same bit slots, pushes its status word out on its serial output. Every bit received after the status word has left is passed on to the next device, delayed by one word. This lets a host address several devices with one long frame.

The block checks the length of each chip-select cycle. The first word is 16 bits, and after it any whole number of 8-bit groups may follow. When chip select rises on a legal length, the last 16 bits received become the new command and a one-cycle strobe marks the update. Any other length is thrown away, and the command output keeps its earlier value. A thermal-fault input forces the serial output high while the device is selected, so a fault seen anywhere reaches the host through every device after it.

All serial pins are sampled on a system clock that runs much faster than SCLK. The pins are taken as already synchronous to that clock.

Top module: `dcs_spi_slave`

## Requirements
- R1: After reset `cmd_o` is 0, `commit_o` is 0 and `so_o` is 0.
- R2: While `csb_n_i` is high, `so_o` is 0 whatever the value of `fault_i`.
- R3: The value on `status_i` is captured when `csb_n_i` falls. It appears on `so_o` MSB first, and the output moves to the next bit on each rising SCLK edge.
- R4: `si_i` is sampled on falling SCLK edges. After the 16 status bits, `so_o` carries the received bits in order, delayed by 16 bit slots.
- R5: A frame of exactly 16 rising SCLK edges loads the 16 received bits into `cmd_o`, with the first bit received as bit 15. The load happens one clock after `csb_n_i` rises.
- R6: A frame of 16 + 8·n rising edges (n ≥ 1) loads the last 16 bits received into `cmd_o`.
- R7: A frame of any other non-zero length (for example 15 or 23) raises no strobe and leaves `cmd_o` unchanged.
- R8: While `csb_n_i` is low and `fault_i` is 1, `so_o` is 1. The fault does not change the bits captured into `cmd_o`.
- R9: `commit_o` is high for exactly one clock per accepted frame, in the same cycle that `cmd_o` takes its new value.
- R10: A chip-select cycle with no SCLK edges is ignored: no strobe is raised and `cmd_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| csb_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idle low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out to the host or the next device |
| status_i | input | 16 | Status word sent out during the next frame |
| fault_i | input | 1 | Thermal fault flag, ORed onto the serial output |
| cmd_o | output | 16 | Last accepted command word |
| commit_o | output | 1 | One-cycle strobe when `cmd_o` is updated |

## Verification
Two sources drive the serial output in the same cycle: the status or pass-through bit that the shift register presents, and the fault flag ORed on top of it. The bench raises the fault during a whole frame whose status word is all zeros. It checks that every bit slot reads 1 and that the command captured in that frame is still exact. A behavioural queue model predicts `so_o`, `cmd_o` and `commit_o` on every clock. Explicit checks per frame cover lengths of 0, 15, 16, 23, 24 and 32 bits.

// File: rtl/dcs_pkg.sv
// Shared types for the chainable SPI receiver.
// Assumes nothing beyond a single system clock domain.
package dcs_pkg;
    // One-clock event flags decoded from the sampled serial pins
    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
    } spi_ev_t;
endpackage

// File: rtl/dcs_spi_edges.sv
// Decodes chip-select and serial-clock edges into one-cycle event flags.
// Assumes csb_n_i and sclk_i are synchronous to clk and are held at least
// one clk period per level. SCLK edges count only while chip select is low.
module dcs_spi_edges
    import dcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    csb_n_i,
    input  logic    sclk_i,
    output spi_ev_t ev_o
);
    logic csb_q;
    logic sclk_q;

    // Keep the previous pin levels so edges can be detected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csb_q  <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            csb_q  <= csb_n_i;
            sclk_q <= sclk_i;
        end
    end

    // Edge flags, with SCLK edges gated by an active chip select
    always_comb begin
        ev_o.cs_fall  = csb_q & ~csb_n_i;
        ev_o.cs_rise  = ~csb_q & csb_n_i;
        ev_o.sck_rise = ~csb_n_i & sclk_i & ~sclk_q;
        ev_o.sck_fall = ~csb_n_i & ~sclk_i & sclk_q;
    end
endmodule

// File: rtl/dcs_shift.sv
// Word-wide shift register shared by the outgoing status word and the
// incoming command. At chip-select fall it loads the status word. Each
// rising SCLK edge moves the MSB to the output bit, and each falling edge
// fills the freed LSB from serial input. After WORD_W bit pairs it holds
// the most recent WORD_W received bits.
module dcs_shift
    import dcs_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi_ev_t           ev_i,
    input  logic              si_i,
    input  logic [WORD_W-1:0] status_i,
    output logic [WORD_W-1:0] word_o,
    output logic              so_bit_o
);
    localparam int MSB = WORD_W - 1;

    logic [WORD_W-1:0] sh_q;
    logic              so_q;

    // Load status, shift out on rise, fill LSB on fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            so_q <= 1'b0;
        end else if (ev_i.cs_fall) begin
            sh_q <= status_i;
            so_q <= status_i[MSB];
        end else if (ev_i.sck_rise) begin
            so_q <= sh_q[MSB];
            sh_q <= {sh_q[MSB-1:0], 1'b0};
        end else if (ev_i.sck_fall) begin
            sh_q[0] <= si_i;
        end
    end

    assign word_o   = sh_q;
    assign so_bit_o = so_q;
endmodule

// File: rtl/dcs_frame_len.sv
// Frame length checker. It counts rising SCLK edges modulo WORD_W until
// the first word is complete, then modulo GROUP_W. The frame is legal when
// the first word is complete and the group counter sits at zero.
module dcs_frame_len
    import dcs_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int GROUP_W = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  spi_ev_t ev_i,
    output logic    frame_ok_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam int GRP_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUP_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [GRP_W-1:0] grp_q;
    logic             done_q;

    // Two-stage counting: first word, then trailing groups
    always_ff @(posedge clk) begin
        if (!rst_n || ev_i.cs_fall) begin
            cnt_q  <= '0;
            grp_q  <= '0;
            done_q <= 1'b0;
        end else if (ev_i.sck_rise) begin
            if (!done_q) begin
                cnt_q  <= cnt_q + 1'b1;
                done_q <= (cnt_q == CNT_LAST);
            end else begin
                grp_q <= (grp_q == GRP_LAST) ? '0 : grp_q + 1'b1;
            end
        end
    end

    assign frame_ok_o = done_q && (grp_q == '0);

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_q) |-> $past(ev_i.cs_fall));
    // R5
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(ev_i.sck_rise));
endmodule

// File: rtl/dcs_spi_slave.sv
// Chainable SPI command receiver with frame-length validation.
// The status word leaves on so_o while the command arrives on si_i. When
// chip select rises on a legal length, the last WORD_W bits go to cmd_o
// with a one-cycle strobe. The fault flag is ORed onto so_o while selected.
// Assumes all serial pins are synchronous to clk and much slower than it.
module dcs_spi_slave
    import dcs_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int GROUP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csb_n_i,
    input  logic              sclk_i,
    input  logic              si_i,
    output logic              so_o,
    input  logic [WORD_W-1:0] status_i,
    input  logic              fault_i,
    output logic [WORD_W-1:0] cmd_o,
    output logic              commit_o
);
    spi_ev_t           ev;
    logic [WORD_W-1:0] word;
    logic              so_bit;
    logic              frame_ok;

    dcs_spi_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .csb_n_i (csb_n_i),
        .sclk_i  (sclk_i),
        .ev_o    (ev)
    );

    dcs_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .si_i     (si_i),
        .status_i (status_i),
        .word_o   (word),
        .so_bit_o (so_bit)
    );

    dcs_frame_len #(.WORD_W(WORD_W), .GROUP_W(GROUP_W)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .frame_ok_o (frame_ok)
    );

    // Commit the received word at chip-select rise on a legal frame only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o    <= '0;
            commit_o <= 1'b0;
        end else begin
            commit_o <= ev.cs_rise && frame_ok;
            if (ev.cs_rise && frame_ok) begin
                cmd_o <= word;
            end
        end
    end

    // Serial output: quiet when deselected, fault ORed in when selected
    assign so_o = ~csb_n_i & (so_bit | fault_i);

    // R5
    commit_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev.cs_rise |=> (commit_o == $past(frame_ok)));
    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_o |-> $stable(cmd_o));
    // R9
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
endmodule

// File: tb/dcs_spi_slave_tb.sv
module dcs_spi_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csb = 1'b1;
    logic        sclk = 1'b0;
    logic        si = 1'b0;
    logic        fault = 1'b0;
    logic [15:0] status = '0;
    logic        so_o;
    logic [15:0] cmd_o;
    logic        commit_o;

    int n_tests = 0;
    int n_fail  = 0;
    int n_commits = 0;
    logic [63:0] so_cap;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dcs_spi_slave u_dut (
        .clk(clk), .rst_n(rst_n), .csb_n_i(csb), .sclk_i(sclk), .si_i(si),
        .so_o(so_o), .status_i(status), .fault_i(fault),
        .cmd_o(cmd_o), .commit_o(commit_o)
    );

    // Behavioural reference model, compared after every clock edge
    bit          m_csb_p = 1'b1;
    bit          m_sclk_p = 1'b0;
    bit          m_so = 1'b0;
    bit          outq[$];
    bit          rxq[$];
    int          nrise = 0;
    logic [15:0] m_cmd = '0;
    bit          m_commit = 1'b0;

    always @(posedge clk) begin
        #2;
        if (!rst_n) begin
            m_csb_p = 1'b1; m_sclk_p = 1'b0; m_so = 1'b0;
            m_cmd = '0; m_commit = 1'b0;
        end else begin
            m_commit = 1'b0;
            if (m_csb_p && !csb) begin
                outq.delete(); rxq.delete(); nrise = 0;
                for (int i = 15; i >= 0; i--) outq.push_back(status[i]);
                m_so = status[15];
            end else if (!m_csb_p && csb) begin
                if (nrise >= 16 && (nrise - 16) % 8 == 0) begin
                    for (int i = 0; i < 16; i++) m_cmd[i] = rxq[rxq.size()-1-i];
                    m_commit = 1'b1;
                end
            end else if (!csb && sclk && !m_sclk_p) begin
                m_so = outq.pop_front();
                nrise++;
            end else if (!csb && !sclk && m_sclk_p) begin
                rxq.push_back(si);
                outq.push_back(si);
            end
            m_csb_p = csb;
            m_sclk_p = sclk;
            if (commit_o) n_commits++;
            n_tests++;
            if (so_o !== (csb ? 1'b0 : (m_so | fault))) begin
                n_fail++;
                $display("FAIL R4 so_o cycle: got %b exp %b", so_o, csb ? 1'b0 : (m_so | fault));
            end
            if (cmd_o !== m_cmd) begin
                n_fail++;
                $display("FAIL R6 cmd_o cycle: got %h exp %h", cmd_o, m_cmd);
            end
            if (commit_o !== m_commit) begin
                n_fail++;
                $display("FAIL R9 commit_o cycle: got %b exp %b", commit_o, m_commit);
            end
        end
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    // Master: data changes on SCLK rise, slave samples on fall
    task automatic send(input logic [63:0] bits, input int n);
        so_cap = '0;
        @(negedge clk) csb = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            si = bits[n-1-i];
            repeat (2) @(negedge clk);
            so_cap = {so_cap[62:0], so_o};
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        csb = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cmd", {48'd0, cmd_o}, 64'd0);
        check("R1 commit", {63'd0, commit_o}, 64'd0);
        check("R1 so", {63'd0, so_o}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 and R3: exact 16-bit frame, status shifted out MSB first
        status = 16'h1234; c0 = n_commits;
        send(64'hA5C3, 16);
        check("R5 cmd", {48'd0, cmd_o}, 64'hA5C3);
        check("R5 one commit", n_commits - c0, 1);
        check("R3 status out", so_cap[15:0], 64'h1234);

        // R7: 15 bits is too short
        c0 = n_commits;
        send(64'h7F0E, 15);
        check("R7 15b cmd held", {48'd0, cmd_o}, 64'hA5C3);
        check("R7 15b no commit", n_commits - c0, 0);

        // R6: 24 bits keeps the last 16
        c0 = n_commits;
        send(64'hF09E3D, 24);
        check("R6 24b cmd", {48'd0, cmd_o}, 64'h9E3D);
        check("R6 24b commit", n_commits - c0, 1);

        // R7: 23 bits is not a whole group
        c0 = n_commits;
        send(64'h5A5A5A, 23);
        check("R7 23b cmd held", {48'd0, cmd_o}, 64'h9E3D);
        check("R7 23b no commit", n_commits - c0, 0);

        // R6 and R4: 32 bits, first word passes through after status
        status = 16'h55AA; c0 = n_commits;
        send(64'hBEEF0F1E, 32);
        check("R6 32b cmd", {48'd0, cmd_o}, 64'h0F1E);
        check("R6 32b commit", n_commits - c0, 1);
        check("R4 pass-through", so_cap[31:0], 64'h55AABEEF);

        // R8: fault forces SO high, command intact
        status = 16'h0000; fault = 1'b1; c0 = n_commits;
        send(64'h3C3C, 16);
        check("R8 so all ones", so_cap[15:0], 64'hFFFF);
        check("R8 cmd intact", {48'd0, cmd_o}, 64'h3C3C);

        // R2: deselected output stays low under fault
        check("R2 so idle", {63'd0, so_o}, 64'd0);
        fault = 1'b0;

        // R10: empty chip-select cycle
        c0 = n_commits;
        send(64'd0, 0);
        check("R10 cmd held", {48'd0, cmd_o}, 64'h3C3C);
        check("R10 no commit", n_commits - c0, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule